// File: doc/BRIEF.md
# Converter Host Register Port

This block is the processor-facing control port of a multi-channel sampling converter. A host reaches it over a 10-bit asynchronous parallel bus with an active-low chip-select, write strobe and read strobe. The block keeps two 8-bit configuration registers. On a write, the two top bus lines act as the register address. The block presents every configuration field to the conversion sequencer as a separate signal. It accepts the sequencer's 10-bit result and formats it for the bus.

The strobes are brought into the system clock domain through a configurable synchronizer chain. A strobe edge takes effect SYNC_STAGES+1 clock edges after it reaches the pins. A read snapshots one output word when it starts and holds that word on the bus until the read strobe returns high. The word is either the coded result or, when readback is on, a register's contents. A read strobe given while the write strobe is held low is a dummy read. It clears both registers to the all-zero default: internal clock, single channel 0, hardware start, straight binary coding, readback off.

Top module: `cvt_host_port`

## Requirements
- R1: After reset both registers hold zero, every configuration output is 0 and bus_oe is 0.
- R2: A write (write strobe rises while chip-select is low) with bus bits 9:8 = 00 stores bits 7:0 in the control register. Bit 7 maps to cfg_soft_start, bit 6 to cfg_status_level, bit 5 to cfg_ext_clk, bit 4 to cfg_pwr_down, bit 3 to cfg_sweep, and bits 2:0 to cfg_chan.
- R3: A write with bits 9:8 = 01 stores the auxiliary register. Bit 6 maps to cfg_fast_osc, bit 3 to cfg_twos, bit 2 to cfg_readback, and bits 1:0 to cfg_sel. Bits 7, 5 and 4 are reserved; they drive no output and read back as don't-care.
- R4: A write strobe that rises while chip-select is high changes neither register.
- R5: A write with bus bits 9:8 = 10 or 11 changes neither register.
- R6: With cfg_readback = 0 and cfg_twos = 0, a read returns conv_result unchanged.
- R7: With cfg_readback = 0 and cfg_twos = 1, a read returns conv_result with bit 9 inverted (two's complement of the mid-scale-offset code).
- R8: With cfg_readback = 1, cfg_sel = 0 returns the control register and cfg_sel = 1 returns the auxiliary register, each on bits 7:0, with bits 9:8 driven 0.
- R9: With cfg_readback = 1 and cfg_sel = 2 or 3, a read returns all zeros.
- R10: bus_oe rises only after a read strobe falls while chip-select is low. It falls after the read strobe rises. A read strobe given with chip-select high never raises it.
- R11: A read strobe that falls while the write strobe is low loads zero into both registers.
- R12: While bus_oe stays high, bus_dout does not change, even if conv_result or the registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Asynchronous chip-select, active low |
| bus_wr_n | input | 1 | Asynchronous write strobe, active low, acts on its rising edge |
| bus_rd_n | input | 1 | Asynchronous read strobe, active low, read opens on its falling edge |
| bus_din | input | RES_W | Bus input lines; top two are the register address on writes |
| bus_dout | output | RES_W | Word driven to the bus during a read |
| bus_oe | output | 1 | Tri-state enable for bus_dout |
| conv_result | input | RES_W | Latest straight-binary result from the sequencer |
| cfg_soft_start | output | 1 | 1: software start, 0: hardware strobe start |
| cfg_status_level | output | 1 | 1: end-of-conversion level, 0: interrupt pulse |
| cfg_ext_clk | output | 1 | 1: external clock, 0: internal oscillator |
| cfg_pwr_down | output | 1 | Software power-down |
| cfg_sweep | output | 1 | 1: channel sweep, 0: single channel |
| cfg_chan | output | 3 | Channel number or sweep set |
| cfg_fast_osc | output | 1 | Oscillator speed, 1 fast |
| cfg_twos | output | 1 | Output coding, 1 two's complement |
| cfg_readback | output | 1 | Reads return register contents |
| cfg_sel | output | 2 | Self-test code or readback target |

## Verification
The bench builds the block with its defaults: a 10-bit result and a two-flop synchronizer. At these values every strobe takes effect three clock edges after the pin changes, so a fixed settle of five cycles per strobe phase gives exact sampling points. A 10-bit word lets the bench reach the bit-9 inversion at both extremes and at mid-scale, and it lets readback reach the zero-filled upper lines. The 8-bit registers make every field position, the reserved bits and all four target codes reachable through ordinary bus reads.

// File: rtl/cvt_host_pkg.sv
package cvt_host_pkg;

   localparam int unsigned REG_W  = 8;
   localparam int unsigned ADDR_W = 2;
   localparam int unsigned CHAN_W = 3;

   // register addresses carried on the top two bus lines
   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'b00;
   localparam logic [ADDR_W-1:0] ADDR_AUX  = 2'b01;

   // readback target codes
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_AUX  = 2'd1;

   // auxiliary bits that are stored; the rest are reserved
   localparam logic [REG_W-1:0] AUX_KEEP = 8'b0100_1111;

   typedef struct packed {
      logic              soft_start;
      logic              status_level;
      logic              ext_clk;
      logic              pwr_down;
      logic              sweep;
      logic [CHAN_W-1:0] chan;
   } ctrl_reg_t;

   typedef struct packed {
      logic       rsv7;
      logic       fast_osc;
      logic       rsv5;
      logic       rsv4;
      logic       twos;
      logic       readback;
      logic [1:0] sel;
   } aux_reg_t;

endpackage

// File: rtl/cvt_strobe_sync.sv
module cvt_strobe_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise,
   output logic fall
);

   if (STAGES < 1) begin : g_bad_stages
      $error("cvt_strobe_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= IDLE_VAL;
         else        chain_q <= async_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/cvt_cfg_regs.sv
module cvt_cfg_regs
   import cvt_host_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              dflt_load,
   output ctrl_reg_t         ctrl_q,
   output aux_reg_t          aux_q
);

   logic hit_ctrl, hit_aux;

   assign hit_ctrl = wr_stb && (wr_addr == ADDR_CTRL);
   assign hit_aux  = wr_stb && (wr_addr == ADDR_AUX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         aux_q  <= '0;
      end else if (dflt_load) begin
         ctrl_q <= '0;
         aux_q  <= '0;
      end else begin
         if (hit_ctrl) ctrl_q <= ctrl_reg_t'(wr_data);
         if (hit_aux)  aux_q  <= aux_reg_t'(wr_data & AUX_KEEP);
      end
   end

endmodule

// File: rtl/cvt_read_port.sv
module cvt_read_port
   import cvt_host_pkg::*;
#(
   parameter int unsigned RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_start,
   input  logic             rd_end,
   input  logic [RES_W-1:0] result,
   input  ctrl_reg_t        ctrl,
   input  aux_reg_t         aux,
   output logic [RES_W-1:0] dout,
   output logic             oe
);

   localparam int unsigned PAD_W = RES_W - REG_W;
   localparam logic [RES_W-1:0] MSB_FLIP = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] coded, reg_word, next_word;

   assign coded = aux.twos ? (result ^ MSB_FLIP) : result;

   always_comb begin
      case (aux.sel)
         SEL_CTRL: reg_word = {{PAD_W{1'b0}}, ctrl};
         SEL_AUX:  reg_word = {{PAD_W{1'b0}}, aux};
         default:  reg_word = '0;
      endcase
   end

   assign next_word = aux.readback ? reg_word : coded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         oe   <= 1'b0;
      end else if (rd_start) begin
         dout <= next_word;
         oe   <= 1'b1;
      end else if (rd_end) begin
         oe   <= 1'b0;
      end
   end

endmodule

// File: rtl/cvt_host_port.sv
module cvt_host_port
   import cvt_host_pkg::*;
#(
   parameter int unsigned RES_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_wr_n,
   input  logic              bus_rd_n,
   input  logic [RES_W-1:0]  bus_din,
   output logic [RES_W-1:0]  bus_dout,
   output logic              bus_oe,
   input  logic [RES_W-1:0]  conv_result,
   output logic              cfg_soft_start,
   output logic              cfg_status_level,
   output logic              cfg_ext_clk,
   output logic              cfg_pwr_down,
   output logic              cfg_sweep,
   output logic [CHAN_W-1:0] cfg_chan,
   output logic              cfg_fast_osc,
   output logic              cfg_twos,
   output logic              cfg_readback,
   output logic [1:0]        cfg_sel
);

   if (RES_W != REG_W + ADDR_W) begin : g_bad_width
      $error("cvt_host_port: RES_W must equal register width plus address width");
   end

   logic cs_level, cs_rise_unused, cs_fall_unused;
   logic wr_level, wr_rise, wr_fall_unused;
   logic rd_level_unused, rd_rise, rd_fall;
   logic wr_stb, rd_start, dflt_load;
   ctrl_reg_t ctrl_q;
   aux_reg_t  aux_q;

   cvt_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .async_in(bus_cs_n),
      .level(cs_level), .rise(cs_rise_unused), .fall(cs_fall_unused));

   cvt_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .async_in(bus_wr_n),
      .level(wr_level), .rise(wr_rise), .fall(wr_fall_unused));

   cvt_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .async_in(bus_rd_n),
      .level(rd_level_unused), .rise(rd_rise), .fall(rd_fall));

   assign wr_stb    = wr_rise && !cs_level;
   assign rd_start  = rd_fall && !cs_level;
   assign dflt_load = rd_fall && !wr_level;

   cvt_cfg_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb),
      .wr_addr(bus_din[RES_W-1 -: ADDR_W]),
      .wr_data(bus_din[REG_W-1:0]),
      .dflt_load(dflt_load),
      .ctrl_q(ctrl_q), .aux_q(aux_q));

   cvt_read_port #(.RES_W(RES_W)) u_read (
      .clk(clk), .rst_n(rst_n),
      .rd_start(rd_start), .rd_end(rd_rise),
      .result(conv_result), .ctrl(ctrl_q), .aux(aux_q),
      .dout(bus_dout), .oe(bus_oe));

   assign cfg_soft_start   = ctrl_q.soft_start;
   assign cfg_status_level = ctrl_q.status_level;
   assign cfg_ext_clk      = ctrl_q.ext_clk;
   assign cfg_pwr_down     = ctrl_q.pwr_down;
   assign cfg_sweep        = ctrl_q.sweep;
   assign cfg_chan         = ctrl_q.chan;
   assign cfg_fast_osc     = aux_q.fast_osc;
   assign cfg_twos         = aux_q.twos;
   assign cfg_readback     = aux_q.readback;
   assign cfg_sel          = aux_q.sel;

endmodule

// File: rtl/cvt_host_port_chk.sv
module cvt_host_port_chk #(
   parameter int unsigned RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_rise,
   input logic             rd_fall,
   input logic             wr_level,
   input logic             cs_level,
   input logic [1:0]       addr,
   input logic [7:0]       ctrl_bits,
   input logic [7:0]       aux_bits,
   input logic             oe,
   input logic [RES_W-1:0] dout
);

   // R4: writes with chip-select high leave both registers alone
   p_cs_high_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && cs_level) |=> ($stable(ctrl_bits) && $stable(aux_bits)));

   // R5: writes to the unused address codes leave both registers alone
   p_bad_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && addr[1]) |=> ($stable(ctrl_bits) && $stable(aux_bits)));

   // R11: a dummy read with the write strobe low clears both registers
   p_default_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && !wr_level) |=> (ctrl_bits == 8'h00 && aux_bits == 8'h00));

   // R10: the bus is enabled only by a chip-selected read edge
   p_oe_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(rd_fall && !cs_level));

   // R12: the driven word holds for the whole read
   p_dout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && $past(oe)) |-> $stable(dout));

   // R3: reserved auxiliary bits never hold a one
   p_reserved_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_bits[7] == 1'b0 && aux_bits[5:4] == 2'b00));

endmodule

bind cvt_host_port cvt_host_port_chk #(.RES_W(RES_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wr_rise(wr_rise), .rd_fall(rd_fall),
   .wr_level(wr_level), .cs_level(cs_level),
   .addr(bus_din[RES_W-1 -: 2]),
   .ctrl_bits(ctrl_q), .aux_bits(aux_q),
   .oe(bus_oe), .dout(bus_dout));

// File: tb/test_cvt_host_port.sv
module test_cvt_host_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [9:0] din = '0;
   logic [9:0] dout;
   logic       oe;
   logic [9:0] res = '0;
   logic       c_soft, c_stat, c_ext, c_pd, c_sweep, c_fast, c_twos, c_rb;
   logic [2:0] c_chan;
   logic [1:0] c_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cvt_host_port i_cvt_host_port (
      .clk(clk), .rst_n(rst_n),
      .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
      .bus_din(din), .bus_dout(dout), .bus_oe(oe),
      .conv_result(res),
      .cfg_soft_start(c_soft), .cfg_status_level(c_stat), .cfg_ext_clk(c_ext),
      .cfg_pwr_down(c_pd), .cfg_sweep(c_sweep), .cfg_chan(c_chan),
      .cfg_fast_osc(c_fast), .cfg_twos(c_twos), .cfg_readback(c_rb), .cfg_sel(c_sel));

   // {aux value, result, expected word, compare mask}
   localparam logic [37:0] VEC [9] = '{
      {8'h00, 10'h155, 10'h155, 10'h3FF},  // R6 straight
      {8'h08, 10'h155, 10'h355, 10'h3FF},  // R7 msb flip
      {8'h08, 10'h3FF, 10'h1FF, 10'h3FF},  // R7 full scale
      {8'h08, 10'h000, 10'h200, 10'h3FF},  // R7 zero scale
      {8'h04, 10'h2AA, 10'h0A5, 10'h3FF},  // R8 control register
      {8'h05, 10'h2AA, 10'h005, 10'h34F},  // R8 aux register, reserved masked
      {8'h06, 10'h2AA, 10'h000, 10'h3FF},  // R9 code 2
      {8'h47, 10'h2AA, 10'h000, 10'h3FF},  // R9 code 3
      {8'h4C, 10'h111, 10'h0A5, 10'h3FF}   // R8 with coding bit set
   };

   task automatic check(input string req, input logic [9:0] act,
                        input logic [9:0] exp, input logic [9:0] mask);
      checks++;
      if ((act & mask) !== (exp & mask)) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act & mask, exp & mask);
      end
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
      @(negedge clk);
      din  = {a, d};
      cs_n = sel_n;
      wr_n = 1'b0;
      settle();
      wr_n = 1'b1;
      settle();
      cs_n = 1'b1;
      settle();
   endtask

   task automatic bus_read(output logic [9:0] word, output logic en, input logic sel_n);
      @(negedge clk);
      cs_n = sel_n;
      rd_n = 1'b0;
      settle();
      word = dout;
      en   = oe;
      rd_n = 1'b1;
      settle();
      cs_n = 1'b1;
      settle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [9:0] w;
      logic       e;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1: reset state
      check("R1 oe", {9'd0, oe}, 10'd0, 10'h3FF);
      check("R1 cfg", {c_soft, c_stat, c_ext, c_pd, c_sweep, c_chan, c_fast, c_twos},
            10'd0, 10'h3FF);
      check("R1 sel/rb", {7'd0, c_rb, c_sel}, 10'd0, 10'h3FF);

      // R2: control register fields
      bus_write(2'b00, 8'hA5, 1'b0);
      check("R2 fields", {2'b00, c_soft, c_stat, c_ext, c_pd, c_sweep, c_chan},
            10'h0A5, 10'h3FF);

      // table walk
      foreach (VEC[i]) begin
         bus_write(2'b01, VEC[i][37:30], 1'b0);
         res = VEC[i][29:20];
         bus_read(w, e, 1'b0);
         check("R10 oe during read", {9'd0, e}, 10'd1, 10'h3FF);
         check("R6/R7/R8/R9 table", w, VEC[i][19:10], VEC[i][9:0]);
      end

      // R3: aux fields after last vector (4C)
      check("R3 fields", {6'd0, c_fast, c_twos, c_rb, 1'b0}, 10'h00E, 10'h3FF);
      check("R3 sel", {8'd0, c_sel}, 10'd0, 10'h3FF);

      // R4: write with chip-select high ignored (readback of control stays A5)
      bus_write(2'b00, 8'h3C, 1'b1);
      bus_read(w, e, 1'b0);
      check("R4 ignored", w, 10'h0A5, 10'h3FF);

      // R5: unused address codes ignored
      bus_write(2'b10, 8'hFF, 1'b0);
      bus_write(2'b11, 8'h00, 1'b0);
      bus_read(w, e, 1'b0);
      check("R5 ignored", w, 10'h0A5, 10'h3FF);
      check("R5 aux kept", {7'd0, c_rb, c_sel}, 10'h004, 10'h3FF);

      // R10: oe released after read, not raised without chip-select
      check("R10 oe idle", {9'd0, oe}, 10'd0, 10'h3FF);
      bus_read(w, e, 1'b1);
      check("R10 no cs", {9'd0, e}, 10'd0, 10'h3FF);

      // R12: word held while result changes mid-read
      bus_write(2'b01, 8'h00, 1'b0);
      res = 10'h123;
      @(negedge clk);
      cs_n = 1'b0;
      rd_n = 1'b0;
      settle();
      res = 10'h3C3;
      settle();
      check("R12 held", dout, 10'h123, 10'h3FF);
      rd_n = 1'b1;
      settle();
      cs_n = 1'b1;
      settle();
      check("R10 oe released", {9'd0, oe}, 10'd0, 10'h3FF);

      // R11: dummy read with write strobe low clears both registers
      bus_write(2'b00, 8'hFF, 1'b0);
      bus_write(2'b01, 8'h4F, 1'b0);
      @(negedge clk);
      wr_n = 1'b0;
      settle();
      rd_n = 1'b0;
      settle();
      rd_n = 1'b1;
      settle();
      wr_n = 1'b1;
      settle();
      check("R11 ctrl cleared", {2'b00, c_soft, c_stat, c_ext, c_pd, c_sweep, c_chan},
            10'd0, 10'h3FF);
      check("R11 aux cleared", {6'd0, c_fast, c_twos, c_rb, 1'b0}, 10'd0, 10'h3FF);
      res = 10'h2F0;
      bus_read(w, e, 1'b0);
      check("R11 straight read", w, 10'h2F0, 10'h3FF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule